// File: doc/BRIEF.md
# Tagged Word Memory with Presence-Bit Synchronization

This block is a small word-addressed memory. Each data word has one extra presence bit that marks it as full or empty. A producer and a consumer can use this bit to hand over single words without any lock. Every request is one atomic read-modify-write. In the same cycle the memory tests the bit of the addressed word and may change it. When the bit is in the wrong state for the operation, the operation is refused and a trap is reported. A refused operation writes nothing.

Six operations are defined:

- A plain load and a plain store, which ignore the presence bit.
- A guarded load that refuses an empty word.
- A consuming load that refuses an empty word and otherwise empties it.
- A filling store that always marks the word full.
- A guarded filling store that refuses a word that is already full.

Every response returns the word's contents as they stood before the operation, together with its presence bit. A surrounding processor then chooses between the data and a trap handler. The presence bits are kept four to a line, in a vector next to each line of words.

Top module: `fe_sync_mem`

## Requirements
- R1: After reset every presence bit is empty (0) and every data word reads 0. rsp_valid is low while reset is asserted.
- R2: A request accepted at a clock edge (req_valid high) gives exactly one response at that edge. rsp_valid is high in the following cycle and low after a cycle with no request. rsp_rdata and rsp_full carry the word's data and presence bit as they stood before the operation.
- R3: Plain load (req_op 3'd0) never traps and changes neither the data nor the presence bit.
- R4: Plain store (req_op 3'd1) writes req_wdata, never traps, and keeps the presence bit unchanged.
- R5: Guarded load (req_op 3'd2) traps when the word is empty and completes without trapping when it is full. It modifies nothing in either case.
- R6: Consuming load (req_op 3'd3) traps when the word is empty. When the word is full, it returns the data and clears the presence bit to empty.
- R7: Filling store (req_op 3'd4) writes req_wdata and sets the presence bit to full, whatever its prior state. It never traps.
- R8: Guarded filling store (req_op 3'd5) traps when the word is full. When the word is empty, it writes req_wdata and sets the presence bit to full.
- R9: An operation that traps leaves both the data word and its presence bit unchanged.
- R10: A request to an address in the cycle right after a modifying request to the same address sees the fully updated word and bit.
- R11: Reserved codes (req_op 3'd6 and 3'd7) never trap and modify nothing.
- R12: An operation changes only the presence bit of its own word. The other three words of the same four-word line keep their bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | DATA_W | Word data before the operation |
| rsp_full | output | 1 | Presence bit before the operation |
| rsp_trap | output | 1 | Operation refused |

## Verification
The bench checks both sides of every guarded operation.

- A guarded filling store is sent to a full word. If that store wrote its data anyway, the following load returns the new data instead of the old.
- A consuming load is run and then the same word is loaded again. A design that forgot to clear the bit reports the word as still full.
- Plain stores go to both full and empty words. A design that let a plain store touch the presence bit shows the wrong bit on the next load.
- A neighbouring word in the same line is loaded after a change to its neighbour. A design that addressed the bit vector by line instead of by word reports that neighbour as full.
- Reserved codes are sent, and a reset is applied in the middle of the run. Both catch stray writes and bits that are not cleared.

// File: rtl/fe_sync_mem.sv
module fe_sync_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int WPL    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_full,
  output logic              rsp_trap
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int OFF_W  = $clog2(WPL);
  localparam int LINES  = DEPTH / WPL;
  localparam int LINE_W = ADDR_W - OFF_W;

  localparam logic [2:0] OP_LD       = 3'd0;
  localparam logic [2:0] OP_ST       = 3'd1;
  localparam logic [2:0] OP_LD_GUARD = 3'd2;
  localparam logic [2:0] OP_LD_TAKE  = 3'd3;
  localparam logic [2:0] OP_ST_FILL  = 3'd4;
  localparam logic [2:0] OP_ST_GUARD = 3'd5;

  logic [DATA_W-1:0] words [DEPTH];
  logic [WPL-1:0]    tags  [LINES];

  logic [LINE_W-1:0] line;
  logic [OFF_W-1:0]  off;
  logic [DATA_W-1:0] cur_data;
  logic              cur_tag;
  logic              trap, data_we, tag_we, tag_nxt;

  assign line     = req_addr[ADDR_W-1:OFF_W];
  assign off      = req_addr[OFF_W-1:0];
  assign cur_data = words[req_addr];
  assign cur_tag  = tags[line][off];

  always_comb begin
    trap    = 1'b0;
    data_we = 1'b0;
    tag_we  = 1'b0;
    tag_nxt = cur_tag;
    unique case (req_op)
      OP_ST:       data_we = 1'b1;
      OP_LD_GUARD: trap = ~cur_tag;
      OP_LD_TAKE: begin
        trap    = ~cur_tag;
        tag_we  = cur_tag;
        tag_nxt = 1'b0;
      end
      OP_ST_FILL: begin
        data_we = 1'b1;
        tag_we  = 1'b1;
        tag_nxt = 1'b1;
      end
      OP_ST_GUARD: begin
        trap    = cur_tag;
        data_we = ~cur_tag;
        tag_we  = ~cur_tag;
        tag_nxt = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) words[i] <= '0;
      for (int j = 0; j < LINES; j++) tags[j] <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_full  <= 1'b0;
      rsp_trap  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_rdata <= cur_data;
        rsp_full  <= cur_tag;
        rsp_trap  <= trap;
        if (data_we) words[req_addr] <= req_wdata;
        if (tag_we)  tags[line][off] <= tag_nxt;
      end else begin
        rsp_trap <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fe_sync_mem_chk.sv
module fe_sync_mem_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [2:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_full,
  input logic              rsp_trap
);
  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R2
  no_rsp_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_trap);
  // R5
  guard_load_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == 3'd2 |=> rsp_trap == !rsp_full);
  // R6
  take_load_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == 3'd3 |=> rsp_trap == !rsp_full);
  // R8
  guard_store_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == 3'd5 |=> rsp_trap == rsp_full);
  // R3 R4 R7 R11
  never_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_op == 3'd0 || req_op == 3'd1 || req_op == 3'd4 || req_op >= 3'd6)
    |=> !rsp_trap);
  // R10
  fill_then_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd4) ##1
    (req_valid && req_op == 3'd0 && req_addr == $past(req_addr))
    |=> rsp_full && rsp_rdata == $past(req_wdata, 2));
  // R6
  take_then_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd3) ##1
    (req_valid && req_op == 3'd0 && req_addr == $past(req_addr))
    |=> !rsp_full);
endmodule

bind fe_sync_mem fe_sync_mem_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .rsp_full(rsp_full), .rsp_trap(rsp_trap)
);

// File: tb/fe_sync_mem_tb_top.sv
`timescale 1ns/1ps
module fe_sync_mem_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_full, rsp_trap;
  logic [31:0] rsp_rdata;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  fe_sync_mem dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_full(rsp_full), .rsp_trap(rsp_trap)
  );

  // {req id, op, addr, wdata, exp data, exp full, exp trap}
  localparam int NV = 23;
  localparam logic [78:0] VEC [NV] = '{
    {4'd1,  3'd0, 6'd0,  32'h0,        32'h0,        1'b0, 1'b0}, // R1
    {4'd5,  3'd2, 6'd0,  32'h0,        32'h0,        1'b0, 1'b1}, // R5 empty
    {4'd6,  3'd3, 6'd0,  32'h0,        32'h0,        1'b0, 1'b1}, // R6 empty
    {4'd8,  3'd5, 6'd0,  32'hAAAA0001, 32'h0,        1'b0, 1'b0}, // R8 empty
    {4'd10, 3'd0, 6'd0,  32'h0,        32'hAAAA0001, 1'b1, 1'b0}, // R10
    {4'd9,  3'd5, 6'd0,  32'hBBBB0000, 32'hAAAA0001, 1'b1, 1'b1}, // R8/R9 full
    {4'd9,  3'd0, 6'd0,  32'h0,        32'hAAAA0001, 1'b1, 1'b0}, // R9
    {4'd12, 3'd0, 6'd1,  32'h0,        32'h0,        1'b0, 1'b0}, // R12
    {4'd5,  3'd2, 6'd0,  32'h0,        32'hAAAA0001, 1'b1, 1'b0}, // R5 full
    {4'd6,  3'd3, 6'd0,  32'h0,        32'hAAAA0001, 1'b1, 1'b0}, // R6 full
    {4'd6,  3'd0, 6'd0,  32'h0,        32'hAAAA0001, 1'b0, 1'b0}, // R6 cleared
    {4'd4,  3'd1, 6'd0,  32'h12345678, 32'hAAAA0001, 1'b0, 1'b0}, // R4
    {4'd4,  3'd0, 6'd0,  32'h0,        32'h12345678, 1'b0, 1'b0}, // R4/R3
    {4'd7,  3'd4, 6'd2,  32'hCAFE0002, 32'h0,        1'b0, 1'b0}, // R7
    {4'd7,  3'd4, 6'd2,  32'hDEAD0003, 32'hCAFE0002, 1'b1, 1'b0}, // R7 again
    {4'd4,  3'd1, 6'd2,  32'h00000005, 32'hDEAD0003, 1'b1, 1'b0}, // R4
    {4'd4,  3'd0, 6'd2,  32'h0,        32'h00000005, 1'b1, 1'b0}, // R4 keeps full
    {4'd11, 3'd6, 6'd2,  32'hFFFFFFFF, 32'h00000005, 1'b1, 1'b0}, // R11
    {4'd11, 3'd7, 6'd2,  32'hEEEEEEEE, 32'h00000005, 1'b1, 1'b0}, // R11
    {4'd11, 3'd0, 6'd2,  32'h0,        32'h00000005, 1'b1, 1'b0}, // R11
    {4'd12, 3'd0, 6'd3,  32'h0,        32'h0,        1'b0, 1'b0}, // R12
    {4'd6,  3'd3, 6'd3,  32'h0,        32'h0,        1'b0, 1'b1}, // R6
    {4'd1,  3'd0, 6'd63, 32'h0,        32'h0,        1'b0, 1'b0}  // R1
  };

  task automatic check(input string req, input logic ok, input logic [34:0] act,
                       input logic [34:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual {valid,data,full,trap}=%h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [5:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state of response
    check("R1", rsp_valid == 1'b0 && rsp_trap == 1'b0,
          {rsp_valid, rsp_rdata, rsp_full, rsp_trap}, 35'h0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][74:72], VEC[i][71:66], VEC[i][65:34]);
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VEC[i][78:75], i),
            rsp_valid && rsp_rdata == VEC[i][33:2] && rsp_full == VEC[i][1]
            && rsp_trap == VEC[i][0],
            {rsp_valid, rsp_rdata, rsp_full, rsp_trap}, {1'b1, VEC[i][33:0]});
    end
    // R2 idle cycle gives no response
    req_valid = 1'b0;
    @(negedge clk);
    check("R2", !rsp_valid && !rsp_trap, {rsp_valid, rsp_rdata, rsp_full, rsp_trap},
          {1'b0, rsp_rdata, rsp_full, 1'b0});
    // R10 consume then guarded load same word, back to back
    issue(3'd4, 6'd9, 32'h00000099);
    @(negedge clk);
    issue(3'd3, 6'd9, 32'h0);
    @(negedge clk);
    check("R10 take", rsp_valid && rsp_rdata == 32'h99 && rsp_full && !rsp_trap,
          {rsp_valid, rsp_rdata, rsp_full, rsp_trap}, {1'b1, 32'h99, 1'b1, 1'b0});
    issue(3'd2, 6'd9, 32'h0);
    @(negedge clk);
    check("R10 guard", rsp_valid && rsp_rdata == 32'h99 && !rsp_full && rsp_trap,
          {rsp_valid, rsp_rdata, rsp_full, rsp_trap}, {1'b1, 32'h99, 1'b0, 1'b1});
    // R1 mid-run reset clears tags and data
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    issue(3'd0, 6'd2, 32'h0);
    @(negedge clk);
    check("R1 after reset", rsp_valid && rsp_rdata == 32'h0 && !rsp_full && !rsp_trap,
          {rsp_valid, rsp_rdata, rsp_full, rsp_trap}, {1'b1, 32'h0, 1'b0, 1'b0});
    req_valid = 1'b0;
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule